// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Controller

The block collects event pulses from a bank of 32 timer channels into sticky flag bits. A mask register decides which flags may raise an interrupt. Software changes the mask and the flags only through strobe addresses, where each bit written as 1 acts and each bit written as 0 does nothing. This means two agents can change different bits without a read-modify-write sequence.

Pending bits are the flags that are not masked. They are merged onto three level-sensitive parent interrupt lines. A static input selects one of two channel-to-line groupings. In grouping 0, channel 0 and channel 1 each drive their own line, and channels 2 to 7 share the third line. In grouping 1, channel 5 drives line 0 alone, channels 0 to 4 and 6 to 7 share line 1, and line 2 is never driven. Channels 8 to 31 have working flag and mask bits but drive no line.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset the flag register reads 0 and the mask register reads all ones. All parent lines are low.
- R2: The register map uses word addresses on `addr_i[2:0]`. Address 0 reads the flags. Address 1 reads the mask. Address 2 sets mask bits on a write of 1s. Address 3 clears mask bits on a write of 1s. Address 4 clears flag bits on a write of 1s. Bits written as 0 leave the state unchanged. Writes to addresses 0, 1 and 5 to 7 are ignored.
- R3: A high `evt_i[n]` sets flag n on the next clock. The flag stays set until a flag-clear write for that bit.
- R4: If an event and a flag-clear write hit the same bit in the same cycle, the flag stays set.
- R5: Pending bits are the flags ANDed with the inverted mask. A flag sets whatever its mask bit is, and it reads back in the flag register even while masked.
- R6: With `grp_sel_i`=0, line 0 = pending[0], line 1 = pending[1], and line 2 = OR of pending[7:2].
- R7: With `grp_sel_i`=1, line 0 = pending[5], line 1 = OR of pending[4:0] and pending[7:6], and line 2 = 0.
- R8: Bits 8 to 31 can be written and read back like the other bits, but they never affect any parent line.
- R9: Reads of addresses 2 to 7 return zero. Read data is combinational from the address.
- R10: The parent lines are level-sensitive and registered. They change one clock after the flags or the mask change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grp_sel_i | input | 1 | Grouping select (0 or 1), static |
| evt_i | input | 32 | Per-channel event pulses |
| addr_i | input | 3 | Register word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| irq_o | output | 3 | Parent interrupt lines |

## Verification
The bench makes an event and a flag-clear write collide on the same bit. A design that gives priority to the clear would lose the event, and the flag would read back as 0. The bench sets and clears masks with sparse bit patterns. A design that writes the whole register instead of acting only on 1 bits would corrupt the bits around the target. The bench drives events on bits 8 to 31 with those bits unmasked, and runs both groupings. A routing error would then show as a wrong line asserting, or as line 2 asserting in grouping 1. Reads of the strobe addresses must return zero, and a design that echoed the mask there would be reported.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned NCH   = 32;
  localparam int unsigned NLINE = 3;
  localparam int unsigned AW    = 3;
  typedef enum logic [AW-1:0] {
    A_FLAG  = 3'd0,
    A_MASK  = 3'd1,
    A_MSET  = 3'd2,
    A_MCLR  = 3'd3,
    A_FCLR  = 3'd4
  } addr_e;
endpackage

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N = NCH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  evt_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  flag_o,
  output logic [N-1:0]  mask_o
);
  logic [N-1:0] mset, mclr, fclr;

  always_comb begin
    mset = '0;
    mclr = '0;
    fclr = '0;
    if (we_i) begin
      unique case (addr_i)
        A_MSET:  mset = wdata_i;
        A_MCLR:  mclr = wdata_i;
        A_FCLR:  fclr = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= '0;
      mask_o <= '1;
    end else begin
      flag_o <= (flag_o & ~fclr) | evt_i; // event wins over clear
      mask_o <= (mask_o & ~mclr) | mset;
    end
  end

  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flag_o & $past(evt_i)) == $past(evt_i))) else $error("R4"); // R4
  AST_MASK_RESET: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (mask_o == '1)) else $error("R1"); // R1
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && evt_i == '0) |=> $stable(flag_o)) else $error("R3"); // R3
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N = NCH,
  parameter int unsigned L = NLINE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         grp_sel_i,
  input  logic [N-1:0] pend_i,
  output logic [L-1:0] irq_o
);
  logic [L-1:0] line_d;

  always_comb begin
    line_d = '0;
    if (!grp_sel_i) begin
      line_d[0] = pend_i[0];
      line_d[1] = pend_i[1];
      line_d[2] = |pend_i[7:2];
    end else begin
      line_d[0] = pend_i[5];
      line_d[1] = |{pend_i[7:6], pend_i[4:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= line_d;
  end

  AST_GRP1_LINE2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(grp_sel_i) |-> !irq_o[2]) else $error("R7"); // R7
  AST_HIGH_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[7:0] == '0) |=> (irq_o == '0)) else $error("R8"); // R8
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          grp_sel_i,
  input  logic [31:0]   evt_i,
  input  logic [2:0]    addr_i,
  input  logic          we_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic [2:0]    irq_o
);
  logic [NCH-1:0] flag, mask, pend;

  tmr_irq_regs #(.N(NCH)) u_regs (
    .clk_i, .rst_ni, .evt_i, .addr_i, .we_i, .wdata_i,
    .flag_o(flag), .mask_o(mask)
  );

  assign pend = flag & ~mask;

  tmr_irq_route #(.N(NCH), .L(NLINE)) u_route (
    .clk_i, .rst_ni, .grp_sel_i, .pend_i(pend), .irq_o
  );

  always_comb begin
    unique case (addr_i)
      A_FLAG:  rdata_o = flag;
      A_MASK:  rdata_o = mask;
      default: rdata_o = '0;
    endcase
  end

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask[7:0] == '1) |=> (irq_o == '0)) else $error("R5"); // R5
  AST_STROBE_RD0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= 3'd2) |-> (rdata_o == '0)) else $error("R9"); // R9
endmodule

// File: tb/tmr_irq_ctrl_test.sv
module tmr_irq_ctrl_test;
  logic clk = 0, rst_n = 0, grp = 0, we = 0;
  logic [31:0] evt = 0, wd = 0, rd;
  logic [2:0] addr = 0, irq;
  int vec = 0, bad = 0;
  logic [31:0] m_flag, m_mask;
  logic [2:0] m_irq;

  always #10 clk = ~clk;

  tmr_irq_ctrl uut (.clk_i(clk), .rst_ni(rst_n), .grp_sel_i(grp), .evt_i(evt),
    .addr_i(addr), .we_i(we), .wdata_i(wd), .rdata_o(rd), .irq_o(irq));

  function automatic logic [2:0] route(logic g, logic [31:0] p);
    logic [2:0] r = 0;
    if (!g) begin r[0]=p[0]; r[1]=p[1]; for (int i=2;i<8;i++) r[2]|=p[i]; end
    else begin
      r[0]=p[5];
      for (int i=0;i<8;i++) if (i!=5) r[1]|=p[i];
    end
    return r;
  endfunction

  // reference model, updated on each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_flag = 0; m_mask = '1; m_irq = 0; end
    else begin
      logic [31:0] nf, nm;
      nf = m_flag; nm = m_mask;
      if (we && addr==4) nf = nf & ~wd;
      nf = nf | evt;
      if (we && addr==2) nm = nm | wd;
      if (we && addr==3) nm = nm & ~wd;
      m_irq = route(grp, m_flag & ~m_mask);
      m_flag = nf; m_mask = nm;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // compare every clock at the negative edge
  always @(negedge clk) if (rst_n) begin
    chk("R6/R7/R10 irq", {29'd0, irq}, {29'd0, m_irq});
    case (addr)
      3'd0: chk("R3 flag read", rd, m_flag);
      3'd1: chk("R2 mask read", rd, m_mask);
      default: chk("R9 strobe read", rd, 32'd0);
    endcase
  end

  task automatic cyc(logic [2:0] a, logic w, logic [31:0] d, logic [31:0] e);
    @(negedge clk); addr = a; we = w; wd = d; evt = e;
    @(posedge clk); #1; we = 0; evt = 0;
  endtask

  initial begin
    #5;
    chk("R1 irq reset", {29'd0, irq}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    addr = 0; #1; chk("R1 flag reset", rd, 0);
    addr = 1; #1; chk("R1 mask reset", rd, '1);
    // R5 masked event latches without irq
    cyc(0, 0, 0, 32'h0000_0003);
    cyc(0, 0, 0, 0);
    chk("R5 no irq while masked", {29'd0, irq}, 0);
    // R2 sparse unmask
    cyc(3, 1, 32'h0000_00A5, 0);
    cyc(1, 0, 0, 0);
    chk("R2 mask clear sparse", rd, 32'hFFFF_FF5A);
    chk("R6 line0 from ch0", {31'd0, irq[0]}, 1);
    // R4 collision
    cyc(4, 1, 32'h1, 32'h1);
    cyc(0, 0, 0, 0);
    chk("R4 event wins", rd & 32'h1, 32'h1);
    cyc(4, 1, 32'h3, 0);
    cyc(0, 0, 0, 0);
    chk("R3 clear", rd, 0);
    // R2 ignored write to flag address
    cyc(0, 1, '1, 0);
    chk("R2 write to flag addr ignored", rd, 0);
    cyc(1, 1, 0, 0); cyc(7, 1, '1, 0);
    cyc(1, 0, 0, 0);
    chk("R2 other addr ignored", rd, 32'hFFFF_FF5A);
    // R8 high bits
    cyc(3, 1, 32'hFFFF_FFFF, 32'hFF00_0000);
    cyc(0, 0, 0, 0);
    chk("R8 high flags read", rd, 32'hFF00_0000);
    chk("R8 no irq", {29'd0, irq}, 0);
    // R6 channel walk, grouping 0
    for (int c = 0; c < 8; c++) begin
      cyc(0, 0, 0, 32'h1 << c); cyc(0, 0, 0, 0);
      cyc(4, 1, '1, 0); cyc(0, 0, 0, 0);
    end
    // R7 grouping 1
    grp = 1;
    for (int c = 0; c < 8; c++) begin
      cyc(0, 0, 0, 32'h1 << c); cyc(0, 0, 0, 0);
      cyc(4, 1, '1, 0); cyc(0, 0, 0, 0);
    end
    // R2 mask set sparse
    cyc(2, 1, 32'h0000_0020, 32'h20);
    cyc(1, 0, 0, 0);
    chk("R2 mask set sparse", rd, 32'h0000_0020);
    chk("R7 masked ch5 quiet", {29'd0, irq}, 0);
    for (int a = 2; a < 8; a++) begin
      addr = a[2:0]; #1; chk("R9 strobe reads zero", rd, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog act=hang exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule